// File: doc/BRIEF.md
# Horizontal Sync Period Stability Monitor

This block times the interval between successive rising edges of a horizontal sync line, in cycles of the local reference clock. From those intervals it decides whether a line signal is present at all and whether its period has settled. A host arms the measurement through a small register port, polls two status flags, and, once the period is settled, issues a capture command. The command freezes the settled period into two readable result registers.

The measurement runs freely while armed. The captured result changes only when the host asks for it, so a later change at the input does not disturb a value that the host is still reading. A period counter that reaches its ceiling means that no sync edge arrived, and the block reports this as a sticky no-signal flag.

Typical results are near 558 counts for a computer-rate signal and near 1705 counts for a 15 kHz video-rate signal.

Top module: `hsync_period_mon`

## Requirements
- R1: After reset, every register address reads back 0.
- R2: A write to address 0 sets the arm bit to write data bit 0, and address 0 read data bit 0 returns the arm bit. The capture command is write data bit 1 at address 0 and always reads back as 0.
- R3: While armed, the period is the number of clock cycles from one synchronized rising sync edge to the next. After a capture, address 1 bits [2:0] hold period bits [10:8] and address 2 bits [7:0] hold period bits [7:0].
- R4: The stable flag (address 0 bit 7) sets once 8 consecutive measured periods each differ from the period before them by at most 2 counts, which takes 9 periods. It does not set sooner.
- R5: A measured period that differs from the previous one by more than 2 counts clears the stable flag and restarts the run of close periods.
- R6: The period counter saturates at 2047. Reaching 2047 sets the overflow flag (address 0 bit 6), which holds while armed even if sync edges return. While the overflow flag is set, the stable flag stays clear.
- R7: Writing 0 to the arm bit clears both the stable flag and the overflow flag.
- R8: A capture command copies the last settled period into the result registers. Between capture commands the result registers do not change, whatever the input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that counts the period |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync line, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for the selected address |

## Verification
The bench checks that the stable flag stays low before the ninth period. An off-by-one run counter would raise it early. Two alternating patterns are used: one differs by 4 counts and must never settle, and one differs by exactly 2 counts and must settle. A wrong difference or a wrong comparison sign would swap these two results. After an overflow the bench resumes the sync pulses and expects the flag to stay set and the stable flag to stay low. A non-sticky flag would drop, and an overflow that did not block stability would raise the stable flag. It also switches the input rate after a capture and expects the old result to remain until the next capture, which catches a result register that follows the live measurement.

// File: rtl/hpm_pkg.sv
`timescale 1ns/1ps
package hpm_pkg;
   // register addresses
   localparam logic [1:0] ADDR_CTRL   = 2'd0;
   localparam logic [1:0] ADDR_RES_HI = 2'd1;
   localparam logic [1:0] ADDR_RES_LO = 2'd2;
   // control / status bit positions
   localparam int BIT_ARM    = 0;
   localparam int BIT_LATCH  = 1;
   localparam int BIT_OVF    = 6;
   localparam int BIT_STABLE = 7;
endpackage

// File: rtl/hpm_sync_edge.sv
`timescale 1ns/1ps
module hpm_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hpm_sync_edge: STAGES must be at least 2");
   end

   // sh[STAGES-1] is the synchronized copy, sh[STAGES] its previous value
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/hpm_counter.sv
`timescale 1ns/1ps
module hpm_counter #(
   parameter int PERIOD_W = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic                rise,
   output logic                per_vld,
   output logic [PERIOD_W-1:0] period,
   output logic                ovf
);
   localparam logic [PERIOD_W-1:0] CNT_MAX = '1;

   logic [PERIOD_W-1:0] cnt;
   logic                seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         seen <= 1'b0;
         ovf  <= 1'b0;
      end else if (!arm) begin
         cnt  <= '0;
         seen <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         if (rise) begin
            cnt  <= PERIOD_W'(1);
            seen <= 1'b1;
         end else if (cnt != CNT_MAX) begin
            cnt <= cnt + PERIOD_W'(1);
         end
         if (cnt == CNT_MAX) ovf <= 1'b1;
      end
   end

   assign per_vld = arm & rise & seen & (cnt != CNT_MAX);
   assign period  = cnt;
endmodule

// File: rtl/hpm_stability.sv
`timescale 1ns/1ps
module hpm_stability #(
   parameter int PERIOD_W    = 11,
   parameter int TOLERANCE   = 2,
   parameter int STABLE_RUNS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                per_vld,
   input  logic [PERIOD_W-1:0] period,
   output logic                stable,
   output logic [PERIOD_W-1:0] stable_period
);
   localparam int RUN_W = $clog2(STABLE_RUNS + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_RUNS - 1);

   if (STABLE_RUNS < 1) begin : g_bad_runs
      $error("hpm_stability: STABLE_RUNS must be at least 1");
   end

   logic [PERIOD_W-1:0] prev;
   logic                have_prev;
   logic [RUN_W-1:0]    run;
   logic                close;

   if (TOLERANCE == 0) begin : g_exact
      assign close = (period == prev);
   end else begin : g_window
      logic [PERIOD_W-1:0] diff;
      assign diff  = (period >= prev) ? (period - prev) : (prev - period);
      assign close = (diff <= PERIOD_W'(TOLERANCE));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev          <= '0;
         have_prev     <= 1'b0;
         run           <= '0;
         stable        <= 1'b0;
         stable_period <= '0;
      end else if (clear) begin
         have_prev <= 1'b0;
         run       <= '0;
         stable    <= 1'b0;
      end else if (per_vld) begin
         prev      <= period;
         have_prev <= 1'b1;
         if (have_prev && close) begin
            if (run < RUN_LAST) begin
               run <= run + RUN_W'(1);
            end else begin
               run           <= RUN_W'(STABLE_RUNS);
               stable        <= 1'b1;
               stable_period <= period;
            end
         end else begin
            run    <= '0;
            stable <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hpm_regs.sv
`timescale 1ns/1ps
module hpm_regs
   import hpm_pkg::*;
#(
   parameter int PERIOD_W = 11,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                stable,
   input  logic                ovf,
   input  logic [PERIOD_W-1:0] stable_period,
   output logic                arm_q,
   output logic                latch_stb,
   output logic [PERIOD_W-1:0] res_q,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int HI_W = PERIOD_W - DATA_W;

   logic ctrl_wr;
   logic unused_wbits;

   assign ctrl_wr      = wr_en && (addr == ADDR_CTRL);
   assign latch_stb    = ctrl_wr && wr_data[BIT_LATCH];
   assign unused_wbits = ^wr_data[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         res_q <= '0;
      end else begin
         if (ctrl_wr)   arm_q <= wr_data[BIT_ARM];
         if (latch_stb) res_q <= stable_period;
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         ADDR_CTRL: begin
            rd_data[BIT_ARM]    = arm_q;
            rd_data[BIT_OVF]    = ovf;
            rd_data[BIT_STABLE] = stable;
         end
         ADDR_RES_HI: rd_data[HI_W-1:0] = res_q[PERIOD_W-1:DATA_W];
         ADDR_RES_LO: rd_data = res_q[DATA_W-1:0];
         default:     rd_data = '0;
      endcase
   end
endmodule

// File: rtl/hsync_period_mon.sv
`timescale 1ns/1ps
module hsync_period_mon #(
   parameter int PERIOD_W    = 11,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TOLERANCE   = 2,
   parameter int STABLE_RUNS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_in,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 8) begin : g_bad_data
      $error("hsync_period_mon: DATA_W must be at least 8");
   end
   if (PERIOD_W <= DATA_W || PERIOD_W > 2 * DATA_W) begin : g_bad_period
      $error("hsync_period_mon: PERIOD_W must lie in (DATA_W, 2*DATA_W]");
   end

   logic                rise;
   logic                arm_q;
   logic                per_vld;
   logic [PERIOD_W-1:0] period;
   logic                ovf;
   logic                stable;
   logic [PERIOD_W-1:0] stable_period;
   logic                latch_stb;
   logic [PERIOD_W-1:0] res_q;

   hpm_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(hsync_in), .rise(rise)
   );

   hpm_counter #(.PERIOD_W(PERIOD_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .arm(arm_q), .rise(rise),
      .per_vld(per_vld), .period(period), .ovf(ovf)
   );

   hpm_stability #(
      .PERIOD_W(PERIOD_W), .TOLERANCE(TOLERANCE), .STABLE_RUNS(STABLE_RUNS)
   ) stab_i (
      .clk(clk), .rst_n(rst_n), .clear(!arm_q || ovf),
      .per_vld(per_vld), .period(period),
      .stable(stable), .stable_period(stable_period)
   );

   hpm_regs #(.PERIOD_W(PERIOD_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .stable(stable), .ovf(ovf), .stable_period(stable_period),
      .arm_q(arm_q), .latch_stb(latch_stb), .res_q(res_q), .rd_data(rd_data)
   );
endmodule

// File: rtl/hpm_checker.sv
`timescale 1ns/1ps
module hpm_checker #(
   parameter int PERIOD_W = 11
) (
   input logic                clk,
   input logic                rst_n,
   input logic                arm,
   input logic                ovf,
   input logic                stable,
   input logic                per_vld,
   input logic                latch,
   input logic [PERIOD_W-1:0] res
);
   // R7
   disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (!ovf && !stable));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && arm) |=> ovf);

   // R6
   ovf_blocks_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && $past(ovf)) |-> !stable);

   // R4
   stable_needs_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable) |-> $past(per_vld));

   // R8
   result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable(res));
endmodule

bind hsync_period_mon hpm_checker #(.PERIOD_W(PERIOD_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .arm(arm_q), .ovf(ovf), .stable(stable),
   .per_vld(per_vld), .latch(latch_stb), .res(res_q)
);

// File: tb/hsync_period_mon_tb_top.sv
`timescale 1ns/1ps
module hsync_period_mon_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // sync generator controls: per_a = 0 turns the line off
   int per_a = 0;
   int per_b = 0;
   bit alt = 0;

   always #10 clk = ~clk;

   hsync_period_mon dut_i (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
   );

   initial begin : gen_sync
      int ph;
      bit use_b;
      int cur;
      ph = 0;
      use_b = 0;
      forever begin
         @(negedge clk);
         if (per_a == 0) begin
            hsync_in = 1'b0;
            ph = 0;
         end else begin
            cur = (alt && use_b) ? per_b : per_a;
            hsync_in = (ph < 4);
            ph++;
            if (ph >= cur) begin
               ph = 0;
               use_b = ~use_b;
            end
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'd0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_result(output int v);
      int hi;
      int lo;
      rd(2'd1, hi);
      rd(2'd2, lo);
      v = hi * 256 + lo;
   endtask

   task automatic t_reset;
      int v;
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 res_hi", v, 0);
      rd(2'd2, v); chk("R1 res_lo", v, 0);
      rd(2'd3, v); chk("R1 spare", v, 0);
   endtask

   task automatic t_arm;
      int v;
      wr(2'd0, 8'h01);
      rd(2'd0, v); chk("R2 arm readback", v, 1);
      wr(2'd0, 8'h02);
      rd(2'd0, v); chk("R2 latch reads 0, arm cleared", v, 0);
   endtask

   task automatic t_settle_558;
      int v;
      per_a = 558; alt = 0;
      wr(2'd0, 8'h01);
      wait_cyc(5 * 558);
      rd(2'd0, v); chk("R4 not stable before 9 periods", v & 8'h80, 0);
      wait_cyc(7 * 558);
      rd(2'd0, v); chk("R4 stable at 558", v, 8'h81);
      wr(2'd0, 8'h03);
      rd(2'd1, v); chk("R3 hi of 558", v, 2);
      rd(2'd2, v); chk("R3 lo of 558", v, 8'h2E);
   endtask

   task automatic t_freeze_1705;
      int v;
      per_a = 1705;
      wait_cyc(3 * 1705);
      rd(2'd0, v); chk("R5 rate change clears stable", v & 8'h80, 0);
      read_result(v); chk("R8 result frozen", v, 558);
      wait_cyc(10 * 1705);
      rd(2'd0, v); chk("R4 stable at 1705", v, 8'h81);
      read_result(v); chk("R8 no update without capture", v, 558);
      wr(2'd0, 8'h03);
      rd(2'd1, v); chk("R3 hi of 1705", v, 6);
      rd(2'd2, v); chk("R3 lo of 1705", v, 8'hA9);
   endtask

   task automatic t_jitter;
      int v;
      per_a = 558; per_b = 562; alt = 1;
      wait_cyc(20 * 560);
      rd(2'd0, v); chk("R5 diff 4 never stable", v & 8'h80, 0);
      per_b = 560;
      wait_cyc(14 * 560);
      rd(2'd0, v); chk("R4 diff 2 settles", v & 8'h80, 8'h80);
      wr(2'd0, 8'h03);
      read_result(v); chk("R8 capture within window", int'(v == 558 || v == 560), 1);
      alt = 0;
   endtask

   task automatic t_disarm;
      int v;
      wr(2'd0, 8'h00);
      wait_cyc(3);
      rd(2'd0, v); chk("R7 disarm clears stable", v, 0);
   endtask

   task automatic t_overflow;
      int v;
      per_a = 0;
      wait_cyc(10);
      wr(2'd0, 8'h01);
      wait_cyc(2000);
      rd(2'd0, v); chk("R6 no overflow below 2047", v, 8'h01);
      wait_cyc(100);
      rd(2'd0, v); chk("R6 overflow set", v, 8'h41);
      per_a = 558;
      wait_cyc(12 * 558);
      rd(2'd0, v); chk("R6 overflow sticky, stable held low", v, 8'h41);
      wr(2'd0, 8'h00);
      wait_cyc(3);
      rd(2'd0, v); chk("R7 disarm clears overflow", v, 0);
      wr(2'd0, 8'h01);
      wait_cyc(12 * 558);
      rd(2'd0, v); chk("R6 rearm recovers stable", v, 8'h81);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_arm();
      t_settle_558();
      t_freeze_1705();
      t_jitter();
      t_disarm();
      t_overflow();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule